// File: doc/BRIEF.md
# Battery Pack Presence Sequencer

This block decides whether a removable single-cell pack is still connected to a linear charger. The charge controller starts it once a finished charge has let the cell voltage sag to the recharge level. The block then runs a two-step probe. First it asks for a small sink current for one timed window and looks at the low-voltage comparator. Then it asks for the precharge current for one more window and looks at the recharge comparator. The battery is declared missing only when the voltage collapses under the sink current and then jumps above the recharge level under the small charge current. Any other outcome reports the pack as present, and the controller starts a fresh charge.

The block also handles recovery after a charge-timer fault. If the fault arrives while the cell sits above the recharge level, the block holds the fault until the voltage falls and then runs the probe. If the fault arrives with the cell already below that level, the block first requests a weak fault current. It keeps that current on until the voltage climbs above the recharge level, then follows the first recovery path. A clear request, given when charging is re-enabled, drops everything at once. Probe windows are counted in ticks of a slow time base supplied from outside. Analog sources and comparators are outside the block.

Top module: `pack_probe_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is low.
- R2: A probe request seen in idle raises the detect-current request in the next cycle. The request stays high until the tick that completes WIN_TICKS ticks of that window.
- R3: If the low-voltage flag is 0 at the tick that closes the detect window, `present_pulse` is high in the next cycle and all current requests drop together.
- R4: If the low-voltage flag is 1 at the tick that closes the detect window, the detect request falls. In the same cycle the precharge request rises and stays high for one window of WIN_TICKS ticks.
- R5: At the tick that closes the precharge window, the block emits `absent_pulse` if the above-recharge flag is 1, and `present_pulse` if it is 0. The block then returns to idle.
- R6: Each result pulse lasts one cycle, and the two pulses are never high together. At most one of the three current requests is high in any cycle. All current requests and `fault_hold` are low while a result pulse is high.
- R7: A timer fault seen in idle while the above-recharge flag is 1 raises `fault_hold` with no current request. The hold lasts until a cycle in which the flag is 0, and the detect window starts in the next cycle.
- R8: A timer fault seen in idle while the above-recharge flag is 0 raises both `fault_hold` and the fault-current request. The fault current stays on while the flag stays 0. It drops in the cycle after the flag reads 1, and the block continues as in R7.
- R9: A clear request returns the block to idle in the next cycle, whatever its state. It takes priority over a window closing in the same cycle, so no result pulse appears.
- R10: Probe and fault requests are ignored when the block is not idle. In idle, a fault request takes priority over a probe request that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe that times the probe windows |
| probe_req | input | 1 | Start pulse from the charge controller |
| tmo_fault | input | 1 | Charge-timer fault pulse |
| clr_req | input | 1 | Clear pulse from a charge-enable toggle |
| bat_low | input | 1 | Cell voltage below the low-voltage threshold |
| bat_above_rch | input | 1 | Cell voltage above the recharge threshold |
| det_cur_req | output | 1 | Request for the small sink (detect) current |
| pre_cur_req | output | 1 | Request for the precharge current |
| flt_cur_req | output | 1 | Request for the weak fault current |
| fault_hold | output | 1 | A timer fault is pending recovery |
| present_pulse | output | 1 | One-cycle pulse: pack present, begin charge |
| absent_pulse | output | 1 | One-cycle pulse: pack absent |

## Verification
Two pairs of events can land in the same cycle. A clear request can arrive in the very cycle a probe window closes, and a timer fault can arrive together with a probe request while the block is idle. The bench uses its own behavioural model to find the cycle in which the window's last tick arrives, and it raises the clear request exactly there. It then judges the result at the outputs: no result pulse must appear, and every request must be low one cycle later. For the second pair, both requests are given at once in idle, and the bench checks that the fault hold wins and no detect current starts.

// File: rtl/pack_probe_pkg.sv
package pack_probe_pkg;

  typedef enum logic [2:0] {
    PS_IDLE     = 3'd0,
    PS_DISCH    = 3'd1,
    PS_CHRG     = 3'd2,
    PS_FLT_LOW  = 3'd3,
    PS_FLT_WAIT = 3'd4
  } pps_state_e;

endpackage

// File: rtl/probe_window.sv
module probe_window #(
  parameter int WIN_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic win_end
);
  localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

  logic [CW-1:0] cnt_q;

  // last tick of the window, seen in the cycle it arrives
  assign win_end = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || win_end) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/probe_fsm.sv
module probe_fsm
  import pack_probe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic probe_req,
  input  logic tmo_fault,
  input  logic clr_req,
  input  logic bat_low,
  input  logic bat_above_rch,
  input  logic win_end,
  output logic win_run,
  output logic det_q,
  output logic pre_q,
  output logic flt_q,
  output logic hold_q,
  output logic pres_q,
  output logic abs_q
);
  pps_state_e state_q, state_d;
  logic       pres_d, abs_d;

  assign win_run = (state_q == PS_DISCH) || (state_q == PS_CHRG);

  always_comb begin
    state_d = state_q;
    pres_d  = 1'b0;
    abs_d   = 1'b0;
    if (clr_req) begin
      state_d = PS_IDLE;
    end else begin
      unique case (state_q)
        PS_IDLE: begin
          if (tmo_fault) begin
            state_d = bat_above_rch ? PS_FLT_WAIT : PS_FLT_LOW;
          end else if (probe_req) begin
            state_d = PS_DISCH;
          end
        end
        PS_DISCH: begin
          if (win_end) begin
            if (bat_low) begin
              state_d = PS_CHRG;
            end else begin
              state_d = PS_IDLE;
              pres_d  = 1'b1;
            end
          end
        end
        PS_CHRG: begin
          if (win_end) begin
            state_d = PS_IDLE;
            abs_d   = bat_above_rch;
            pres_d  = !bat_above_rch;
          end
        end
        PS_FLT_LOW: begin
          if (bat_above_rch) state_d = PS_FLT_WAIT;
        end
        PS_FLT_WAIT: begin
          if (!bat_above_rch) state_d = PS_DISCH;
        end
        default: state_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      det_q   <= 1'b0;
      pre_q   <= 1'b0;
      flt_q   <= 1'b0;
      hold_q  <= 1'b0;
      pres_q  <= 1'b0;
      abs_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      det_q   <= (state_d == PS_DISCH);
      pre_q   <= (state_d == PS_CHRG);
      flt_q   <= (state_d == PS_FLT_LOW);
      hold_q  <= (state_d == PS_FLT_LOW) || (state_d == PS_FLT_WAIT);
      pres_q  <= pres_d;
      abs_q   <= abs_d;
    end
  end
endmodule

// File: rtl/pack_probe_seq.sv
module pack_probe_seq #(
  parameter int WIN_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic probe_req,
  input  logic tmo_fault,
  input  logic clr_req,
  input  logic bat_low,
  input  logic bat_above_rch,
  output logic det_cur_req,
  output logic pre_cur_req,
  output logic flt_cur_req,
  output logic fault_hold,
  output logic present_pulse,
  output logic absent_pulse
);
  logic win_run;
  logic win_end;

  probe_window #(.WIN_TICKS(WIN_TICKS)) u_win (
    .clk     (clk),
    .rst     (rst),
    .run     (win_run),
    .tick    (tick),
    .win_end (win_end)
  );

  probe_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .probe_req     (probe_req),
    .tmo_fault     (tmo_fault),
    .clr_req       (clr_req),
    .bat_low       (bat_low),
    .bat_above_rch (bat_above_rch),
    .win_end       (win_end),
    .win_run       (win_run),
    .det_q         (det_cur_req),
    .pre_q         (pre_cur_req),
    .flt_q         (flt_cur_req),
    .hold_q        (fault_hold),
    .pres_q        (present_pulse),
    .abs_q         (absent_pulse)
  );
endmodule

// File: rtl/pack_probe_chk.sv
module pack_probe_chk (
  input logic clk,
  input logic rst,
  input logic clr_req,
  input logic bat_above_rch,
  input logic det_cur_req,
  input logic pre_cur_req,
  input logic flt_cur_req,
  input logic fault_hold,
  input logic present_pulse,
  input logic absent_pulse
);
  AST_ONE_CURRENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({det_cur_req, pre_cur_req, flt_cur_req})); // R6

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(present_pulse && absent_pulse)); // R6

  AST_PRESENT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    present_pulse |=> !present_pulse); // R6

  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (present_pulse || absent_pulse) |->
      !(det_cur_req || pre_cur_req || flt_cur_req || fault_hold)); // R3

  AST_ABSENT_AFTER_CHG: assert property (@(posedge clk) disable iff (rst)
    absent_pulse |-> $past(pre_cur_req)); // R5

  AST_CHG_AFTER_DET: assert property (@(posedge clk) disable iff (rst)
    $rose(pre_cur_req) |-> $past(det_cur_req)); // R4

  AST_FLT_ONLY_BELOW: assert property (@(posedge clk) disable iff (rst)
    flt_cur_req |-> !$past(bat_above_rch)); // R8

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(clr_req) |-> !(det_cur_req || pre_cur_req || flt_cur_req ||
                         fault_hold || present_pulse || absent_pulse)); // R9
endmodule

bind pack_probe_seq pack_probe_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .clr_req       (clr_req),
  .bat_above_rch (bat_above_rch),
  .det_cur_req   (det_cur_req),
  .pre_cur_req   (pre_cur_req),
  .flt_cur_req   (flt_cur_req),
  .fault_hold    (fault_hold),
  .present_pulse (present_pulse),
  .absent_pulse  (absent_pulse)
);

// File: tb/pack_probe_seq_tb_top.sv
`timescale 1ns/1ps
module pack_probe_seq_tb_top;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst, tick, probe_req, tmo_fault, clr_req, bat_low, bat_above_rch;
  logic det_cur_req, pre_cur_req, flt_cur_req, fault_hold, present_pulse, absent_pulse;

  int n_checks = 0;
  int n_errors = 0;
  int n_pres   = 0;
  int n_abs    = 0;
  int tcnt     = 0;
  bit finished = 1'b0;

  // behavioural reference: 0 idle, 1 detect, 2 precharge, 3 fault low, 4 fault wait
  int m_st  = 0;
  int m_cnt = 0;
  bit m_pres = 0, m_abs = 0, m_close = 0;

  always #2 clk = ~clk;

  pack_probe_seq #(.WIN_TICKS(WIN)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .probe_req(probe_req),
    .tmo_fault(tmo_fault), .clr_req(clr_req), .bat_low(bat_low),
    .bat_above_rch(bat_above_rch), .det_cur_req(det_cur_req),
    .pre_cur_req(pre_cur_req), .flt_cur_req(flt_cur_req),
    .fault_hold(fault_hold), .present_pulse(present_pulse),
    .absent_pulse(absent_pulse)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_pres = 0; m_abs = 0;
    end else begin
      m_pres  = 0;
      m_abs   = 0;
      m_close = (m_st == 1 || m_st == 2) && tick && (m_cnt == WIN - 1);
      if (!(m_st == 1 || m_st == 2) || m_close) m_cnt = 0;
      else if (tick) m_cnt = m_cnt + 1;
      if (clr_req) m_st = 0;
      else begin
        case (m_st)
          0: if (tmo_fault) m_st = bat_above_rch ? 4 : 3;
             else if (probe_req) m_st = 1;
          1: if (m_close) begin
               if (bat_low) m_st = 2;
               else begin m_st = 0; m_pres = 1; end
             end
          2: if (m_close) begin
               m_st = 0;
               if (bat_above_rch) m_abs = 1; else m_pres = 1;
             end
          3: if (bat_above_rch) m_st = 4;
          default: if (!bat_above_rch) m_st = 1;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2", "det_cur_req",   det_cur_req,   m_st == 1);
      check("R4", "pre_cur_req",   pre_cur_req,   m_st == 2);
      check("R8", "flt_cur_req",   flt_cur_req,   m_st == 3);
      check("R7", "fault_hold",    fault_hold,    m_st == 3 || m_st == 4);
      check("R3", "present_pulse", present_pulse, m_pres);
      check("R5", "absent_pulse",  absent_pulse,  m_abs);
      if (present_pulse) n_pres++;
      if (absent_pulse)  n_abs++;
    end
  end

  task automatic step();
    @(negedge clk);
    probe_req = 0; tmo_fault = 0; clr_req = 0;
    tcnt++;
    tick = (tcnt % 3 == 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual hung expected done");
    wrap_up();
  end

  initial begin
    rst = 1; tick = 0; probe_req = 0; tmo_fault = 0; clr_req = 0;
    bat_low = 0; bat_above_rch = 0;
    run(4);
    check("R1", "outputs in reset",
          {det_cur_req, pre_cur_req, flt_cur_req, fault_hold, present_pulse, absent_pulse}, 0);
    step(); rst = 0;
    step();
    check("R1", "outputs after reset",
          {det_cur_req, pre_cur_req, flt_cur_req, fault_hold, present_pulse, absent_pulse}, 0);

    // pack stays up under the sink current: present
    step(); probe_req = 1;
    step();
    check("R2", "detect starts", det_cur_req, 1);
    run(60);
    check("R3", "present count", n_pres, 1);

    // collapse then jump: absent
    bat_low = 1; bat_above_rch = 1;
    step(); probe_req = 1;
    run(70);
    check("R5", "absent count", n_abs, 1);

    // collapse but no jump: present
    bat_above_rch = 0;
    step(); probe_req = 1;
    run(70);
    check("R5", "present after charge test", n_pres, 2);

    // fault above the recharge level
    bat_low = 0; bat_above_rch = 1;
    step(); tmo_fault = 1;
    step();
    check("R7", "hold without current", {fault_hold, flt_cur_req, det_cur_req}, 3'b100);
    run(10);
    bat_above_rch = 0;
    step();
    check("R7", "detect after drop", det_cur_req, 1);
    run(60);
    check("R7", "present after recovery", n_pres, 3);

    // fault below the recharge level
    step(); tmo_fault = 1;
    step();
    check("R8", "fault current on", flt_cur_req, 1);
    run(10);
    bat_above_rch = 1;
    step();
    check("R8", "fault current off, hold kept", {flt_cur_req, fault_hold}, 2'b01);
    bat_above_rch = 0; bat_low = 1;
    step();
    check("R8", "detect after second path", det_cur_req, 1);
    run(70);
    check("R8", "present after second path", n_pres, 4);

    // clear landing on the closing tick of the detect window
    bat_low = 0;
    step(); probe_req = 1;
    for (int i = 0; i < 100; i++) begin
      step();
      if (m_st == 1 && m_cnt == WIN - 1 && tick) begin
        clr_req = 1;
        break;
      end
    end
    step();
    check("R9", "all low after clear",
          {det_cur_req, pre_cur_req, flt_cur_req, fault_hold, present_pulse, absent_pulse}, 0);
    run(40);
    check("R9", "no result after clear", n_pres + n_abs, 5);

    // requests while busy are ignored
    step(); probe_req = 1;
    step();
    step(); tmo_fault = 1; probe_req = 1;
    step();
    check("R10", "no hold while busy", fault_hold, 0);
    run(60);
    check("R10", "single present", n_pres, 5);

    // fault and probe together in idle: fault wins
    bat_above_rch = 1;
    step(); tmo_fault = 1; probe_req = 1;
    step();
    check("R10", "fault over probe", {fault_hold, det_cur_req}, 2'b10);
    clr_req = 1;
    step();
    check("R9", "hold cleared", fault_hold, 0);
    run(3);
    check("R6", "absent total", n_abs, 1);
    wrap_up();
  end
endmodule